// File: doc/BRIEF.md
# Output-Queue Emulating Timestamp Allocator

This block sits in a router pipeline right after route computation, where a conventional input-buffered router would run switch arbitration. Every cycle it takes up to one request from each of the router's five input ports. Each request names the output port the flit is bound for. For each request it returns the future cycle in which that flit would leave if the router were an ideal output-queued router that serves each output first-come-first-served. A later stage moves the flit into a middle buffer and reads it out when the free-running current time reaches its timestamp. That stage can fail, for example when no conflict-free buffer is available. It then hands the timestamp back through the cancel input.

The block keeps a free-running 6-bit current-time counter and one 6-bit "last assigned" counter per output. Each output lane carries a two-state status. The status is IDLE when the lane has no departure scheduled after the current cycle. It is QUEUED when the last assigned value lies 1 to 31 cycles ahead of the current time. Three transitions are defined. GRANT moves an IDLE lane to QUEUED or keeps a lane QUEUED. DRAIN moves a QUEUED lane back to IDLE once time catches up with its last value. ROLLBACK lowers the last value by one and may also bring about DRAIN. When a lane is IDLE, its stored value follows the current time, so a stale value can never wrap around and look like a future one. Grants are combinational in the request cycle. Counters update at the next clock edge.

Top module: `ts_alloc_top`

## Requirements
- R1: A synchronous active-high reset sets the current time to 0 and leaves every output lane IDLE, so the first request to any output after reset, presented while the current time is 0, gets timestamp 1.
- R2: `now_time` advances by exactly 1 per clock cycle, modulo 64, while not in reset.
- R3: A single request to output o gets timestamp max(now+1, last_o+1), where last_o is the most recent timestamp granted to o that still lies ahead of now. The timestamp is output in the same cycle as the request, on slice `gnt_ts[6*i +: 6]` of the requesting input i.
- R4: When k requests target one output in the same cycle, they get k consecutive timestamps. The request on the lower input index gets the smaller value.
- R5: A request whose timestamp would lie more than 31 cycles ahead of now is refused. Its `gnt_valid` bit is 0 and it does not advance its output's counter. Every later same-output request in that cycle is refused as well.
- R6: A request whose destination field is 5, 6 or 7 is never granted and has no effect on any output counter.
- R7: A cancel whose output and timestamp match that output's last assigned value, while that value is still ahead of now, lowers the output's counter by one. Requests in the same cycle already see the lowered value.
- R8: A cancel whose timestamp does not match, or whose output is IDLE, has no effect.
- R9: `gnt_ts` slices of requests that are not granted read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 5 | One request bit per input port |
| req_dest | input | 15 | Output port per input, 3 bits each, input i at bits [3i+2:3i] |
| cancel_valid | input | 1 | Return of a previously granted timestamp |
| cancel_dest | input | 3 | Output port of the returned timestamp |
| cancel_ts | input | 6 | Returned timestamp value |
| gnt_valid | output | 5 | Grant flag per input port |
| gnt_ts | output | 30 | Granted timestamp per input, 6 bits each, input i at bits [6i+5:6i] |
| now_time | output | 6 | Free-running current time |

## Verification
The bench drives all five inputs at one output in the same cycle. A design that ranked the requests in the wrong order, or that reused a value, would return swapped or duplicate timestamps. It also floods one output until the 31-cycle horizon is reached. A design without the horizon check would hand out timestamps that alias with past cycles after wraparound. A design that kept counting after a refusal would leave gaps in the sequence. It tests cancels that match, that do not match, and that arrive in the same cycle as a new request. A wrong rollback would show up as a skipped or duplicated departure cycle. Long idle stretches run the time counter through several wraps, where a lane that did not track the current time would return stale, far-future timestamps.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    // Status of one output lane relative to the current time.
    typedef enum logic [0:0] {
        LANE_IDLE   = 1'b0,   // nothing scheduled after the current cycle
        LANE_QUEUED = 1'b1    // last granted departure lies ahead of now
    } lane_state_e;

endpackage

// File: rtl/tsa_clock.sv
module tsa_clock #(
    parameter int TSW = 6
) (
    input  logic           clk,
    input  logic           rst,
    output logic [TSW-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + TSW'(1);
    end

    AST_NOW_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> now == $past(now) + TSW'(1)); // R2

endmodule

// File: rtl/tsa_lane.sv
module tsa_lane
    import tsa_pkg::*;
#(
    parameter int NPORT = 5,
    parameter int TSW   = 6,
    parameter int DW    = 3,
    parameter int LANE  = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TSW-1:0]         now,
    input  logic [NPORT-1:0]       req_valid,
    input  logic [NPORT*DW-1:0]    req_dest,
    input  logic                   cancel_valid,
    input  logic [DW-1:0]          cancel_dest,
    input  logic [TSW-1:0]         cancel_ts,
    output logic [NPORT-1:0]       lane_ok,
    output logic [NPORT*TSW-1:0]   lane_ts
);

    localparam int OW      = TSW + 2;
    localparam int HORIZON = (1 << (TSW - 1)) - 1;

    logic [NPORT-1:0]  hit;
    logic [TSW-1:0]    last_q;
    logic [TSW-1:0]    last_d;
    logic [TSW-1:0]    gap;
    logic [TSW-1:0]    eff_last;
    logic [TSW-1:0]    eff_gap;
    lane_state_e       state;
    lane_state_e       eff_state;
    logic              rollback;
    logic [OW-1:0]     base_off;
    logic [OW-1:0]     cnt;
    logic [OW-1:0]     off_v;

    // Requests aimed at this lane.
    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_hit
            assign hit[gi] = req_valid[gi] && (req_dest[gi*DW +: DW] == DW'(LANE));
        end
    endgenerate

    // Lane status and cancel rollback.
    always_comb begin
        gap      = last_q - now;
        state    = (gap != '0 && !gap[TSW-1]) ? LANE_QUEUED : LANE_IDLE;
        rollback = cancel_valid && (cancel_dest == DW'(LANE)) &&
                   (cancel_ts == last_q) && (state == LANE_QUEUED);
        eff_last = rollback ? last_q - TSW'(1) : last_q;
        eff_gap  = eff_last - now;
        eff_state = (eff_gap != '0 && !eff_gap[TSW-1]) ? LANE_QUEUED : LANE_IDLE;
    end

    // Grant computation in input-index order.
    always_comb begin
        unique case (eff_state)
            LANE_IDLE:   base_off = OW'(1);
            LANE_QUEUED: base_off = OW'(eff_gap) + OW'(1);
            default:     base_off = OW'(1);
        endcase
        cnt     = '0;
        off_v   = '0;
        lane_ok = '0;
        lane_ts = '0;
        for (int i = 0; i < NPORT; i++) begin
            off_v = base_off + cnt;
            if (hit[i] && off_v <= OW'(HORIZON)) begin
                lane_ok[i]             = 1'b1;
                lane_ts[i*TSW +: TSW]  = now + off_v[TSW-1:0];
                cnt                    = cnt + OW'(1);
            end
        end
    end

    // Next value of the last-assigned counter.
    always_comb begin
        if (cnt != '0) begin
            last_d = now + base_off[TSW-1:0] + cnt[TSW-1:0] - TSW'(1);
        end else begin
            unique case (eff_state)
                LANE_QUEUED: last_d = eff_last;
                LANE_IDLE:   last_d = now;
                default:     last_d = now;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= last_d;
    end

    // Stored value stays within one cycle behind to HORIZON ahead of now.
    AST_LAST_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (gap <= TSW'(HORIZON)) || (gap == '1)); // R5

    AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (lane_ok & ~hit) == '0); // R6

    AST_ROLLBACK_STEP: assert property (@(posedge clk) disable iff (rst)
        (rollback && hit == '0) |=> last_q == $past(last_q) - TSW'(1)); // R7

    AST_NO_GRANT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (hit == '0 && !rollback && state == LANE_QUEUED) |=> $stable(last_q)); // R8

endmodule

// File: rtl/tsa_gather.sv
module tsa_gather #(
    parameter int NPORT = 5,
    parameter int TSW   = 6,
    parameter int DW    = 3
) (
    input  logic [NPORT*DW-1:0]         req_dest,
    input  logic [NPORT*NPORT-1:0]      ok_all,
    input  logic [NPORT*NPORT*TSW-1:0]  ts_all,
    output logic [NPORT-1:0]            gnt_valid,
    output logic [NPORT*TSW-1:0]        gnt_ts
);

    always_comb begin
        gnt_valid = '0;
        gnt_ts    = '0;
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                if (req_dest[i*DW +: DW] == DW'(o) && ok_all[o*NPORT + i]) begin
                    gnt_valid[i]          = 1'b1;
                    gnt_ts[i*TSW +: TSW]  = ts_all[(o*NPORT + i)*TSW +: TSW];
                end
            end
        end
    end

endmodule

// File: rtl/ts_alloc_top.sv
module ts_alloc_top #(
    parameter int NPORT = 5,
    parameter int TSW   = 6,
    parameter int DW    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORT-1:0]      req_valid,
    input  logic [NPORT*DW-1:0]   req_dest,
    input  logic                  cancel_valid,
    input  logic [DW-1:0]         cancel_dest,
    input  logic [TSW-1:0]        cancel_ts,
    output logic [NPORT-1:0]      gnt_valid,
    output logic [NPORT*TSW-1:0]  gnt_ts,
    output logic [TSW-1:0]        now_time
);

    localparam int HORIZON = (1 << (TSW - 1)) - 1;

    logic [NPORT*NPORT-1:0]     ok_all;
    logic [NPORT*NPORT*TSW-1:0] ts_all;

    tsa_clock #(.TSW(TSW)) i_clock (
        .clk (clk),
        .rst (rst),
        .now (now_time)
    );

    genvar go;
    generate
        for (go = 0; go < NPORT; go++) begin : g_lane
            tsa_lane #(
                .NPORT (NPORT),
                .TSW   (TSW),
                .DW    (DW),
                .LANE  (go)
            ) i_lane (
                .clk          (clk),
                .rst          (rst),
                .now          (now_time),
                .req_valid    (req_valid),
                .req_dest     (req_dest),
                .cancel_valid (cancel_valid),
                .cancel_dest  (cancel_dest),
                .cancel_ts    (cancel_ts),
                .lane_ok      (ok_all[go*NPORT +: NPORT]),
                .lane_ts      (ts_all[go*NPORT*TSW +: NPORT*TSW])
            );
        end
    endgenerate

    tsa_gather #(.NPORT(NPORT), .TSW(TSW), .DW(DW)) i_gather (
        .req_dest  (req_dest),
        .ok_all    (ok_all),
        .ts_all    (ts_all),
        .gnt_valid (gnt_valid),
        .gnt_ts    (gnt_ts)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_chk
            AST_TS_WINDOW: assert property (@(posedge clk) disable iff (rst)
                gnt_valid[gp] |-> ((gnt_ts[gp*TSW +: TSW] - now_time) != '0) &&
                                  ((gnt_ts[gp*TSW +: TSW] - now_time) <= TSW'(HORIZON))); // R5
            AST_BAD_DEST: assert property (@(posedge clk) disable iff (rst)
                (req_dest[gp*DW +: DW] >= DW'(NPORT)) |-> !gnt_valid[gp]); // R6
            AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
                !gnt_valid[gp] |-> gnt_ts[gp*TSW +: TSW] == '0); // R9
            AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (rst)
                !req_valid[gp] |-> !gnt_valid[gp]); // R3
        end
    endgenerate

endmodule

// File: tb/test_ts_alloc_top.sv
module test_ts_alloc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 5;
    localparam int TW  = 6;
    localparam int DWB = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     req_valid = '0;
    logic [NP*DWB-1:0] req_dest = '0;
    logic              cancel_valid = 1'b0;
    logic [DWB-1:0]    cancel_dest = '0;
    logic [TW-1:0]     cancel_ts = '0;
    logic [NP-1:0]     gnt_valid;
    logic [NP*TW-1:0]  gnt_ts;
    logic [TW-1:0]     now_time;

    int checks = 0;
    int errors = 0;
    int now_m = 0;
    int last_m [NP];
    logic          exp_ok [NP];
    logic [TW-1:0] exp_ts [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_alloc_top i_ts_alloc_top (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_dest     (req_dest),
        .cancel_valid (cancel_valid),
        .cancel_dest  (cancel_dest),
        .cancel_ts    (cancel_ts),
        .gnt_valid    (gnt_valid),
        .gnt_ts       (gnt_ts),
        .now_time     (now_time)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at time %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Reference model: cancel first, then requests in index order.
    function automatic void model_cycle();
        int cd;
        int ts;
        cd = int'(cancel_dest);
        if (cancel_valid && cd < NP && last_m[cd] > now_m &&
            (last_m[cd] % 64) == int'(cancel_ts))
            last_m[cd] = last_m[cd] - 1;
        for (int i = 0; i < NP; i++) begin
            int d;
            d = int'(req_dest[i*DWB +: DWB]);
            exp_ok[i] = 1'b0;
            exp_ts[i] = '0;
            if (req_valid[i] && d < NP) begin
                ts = max2(now_m + 1, last_m[d] + 1);
                if (ts - now_m <= 31) begin
                    exp_ok[i] = 1'b1;
                    exp_ts[i] = TW'(ts % 64);
                    last_m[d] = ts;
                end
            end
        end
    endfunction

    // Inputs are already set after a negedge; check, then advance one cycle.
    task automatic step(input string tag);
        #1;
        model_cycle();
        check({tag, " now_time (R2)"}, int'(now_time), now_m % 64);
        for (int i = 0; i < NP; i++) begin
            string t;
            t = tag;
            if (int'(req_dest[i*DWB +: DWB]) >= NP) t = "R6";
            check({t, " valid"}, int'(gnt_valid[i]), int'(exp_ok[i]));
            check({t, " ts (R9 when idle)"}, int'(gnt_ts[i*TW +: TW]), int'(exp_ts[i]));
        end
        @(posedge clk);
        now_m++;
        @(negedge clk);
        req_valid    = '0;
        cancel_valid = 1'b0;
    endtask

    task automatic set_req(input int port, input int dest);
        req_valid[port] = 1'b1;
        req_dest[port*DWB +: DWB] = DWB'(dest);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NP; i++) last_m[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 now in reset", int'(now_time), 0);
        rst = 1'b0;

        // R1, R4: five requests to output 2 in the first cycle after reset.
        for (int i = 0; i < NP; i++) set_req(i, 2);
        #1;
        check("R1 first grant", int'(gnt_ts[0 +: TW]), 1);
        check("R4 last of burst", int'(gnt_ts[4*TW +: TW]), 5);
        step("R4");

        // R8: mismatching cancel, request must get 6.
        cancel_valid = 1'b1; cancel_dest = 3'd2; cancel_ts = 6'd4;
        set_req(0, 2);
        step("R8");

        // R7: cancel 6 and request together, request reuses 6.
        cancel_valid = 1'b1; cancel_dest = 3'd2; cancel_ts = 6'd6;
        set_req(1, 2);
        #1;
        check("R7 reuse", int'(gnt_ts[1*TW +: TW]), 6);
        step("R7");

        // R6: invalid destinations.
        set_req(0, 5); set_req(1, 6); set_req(2, 7);
        step("R6");

        // R5: flood output 0 until the horizon refuses.
        for (int c = 0; c < 9; c++) begin
            for (int i = 0; i < NP; i++) set_req(i, 0);
            step("R5");
        end

        // R3: drain, then idle lanes follow time across a wrap.
        for (int c = 0; c < 80; c++) step("R3");
        set_req(3, 0);
        step("R3");

        // Random mix.
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NP; i++) begin
                if ($urandom_range(0, 99) < 40) begin
                    int d;
                    d = ($urandom_range(0, 19) == 0) ? int'($urandom_range(5, 7))
                                                      : int'($urandom_range(0, 4));
                    set_req(i, d);
                end
            end
            if ($urandom_range(0, 99) < 20) begin
                int cd;
                cd = int'($urandom_range(0, 4));
                cancel_valid = 1'b1;
                cancel_dest  = DWB'(cd);
                cancel_ts    = ($urandom_range(0, 1) == 1) ? TW'(last_m[cd] % 64)
                                                           : TW'($urandom_range(0, 63));
            end
            step("R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule